// File: doc/BRIEF.md
# DMA Interrupt Register and Channel Trigger

This block keeps the register state that sits between software and a set of DMA channels. It holds a per-channel enable register, one control register per channel, and an interrupt register. The interrupt register mixes plain read/write fields, per-channel completion flags that software acknowledges by writing ones, and a sticky latch that remembers whether an interrupt request has already gone out. Software writes over a simple 32-bit bus addressed by byte offset. Register contents can be read back through a combinational read port.

Writing a channel control register with its start bit set launches that channel, but only when the channel is enabled in the enable register. Channels report completion through done inputs. A completion raises the channel's flag if its interrupt enable is on. Whenever the interrupt condition turns true while the sent latch is clear, the block emits a single-cycle request toward bit 3 of the system interrupt controller. The latch then holds off further requests until the condition has gone false again.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset every register reads zero and no pulse is output. Offsets that map to no register read zero.
- R2: A write to the interrupt register (offset 0xF4) loads bits 0..5, bit 15 (bus error), bits 16..22 (channel interrupt enables) and bit 23 (global enable) from the written data. Bits 6..14 always read zero.
- R3: Flag bits 24..30 of the interrupt register are cleared by writing 1 and kept by writing 0. A write can never set a flag, and bit 31 cannot be written.
- R4: A one-cycle pulse on done input n sets flag bit 24+n only while enable bit 16+n is set. Otherwise the pulse has no effect.
- R5: The interrupt condition is true when the global enable and at least one flag are set, or when the bus-error bit is set.
- R6: While the condition holds, bit 31 (sent) reads one. A request pulse lasting one cycle appears in the cycle after the update, and only if sent was clear before that update.
- R7: Sent clears as soon as the condition becomes false, so the next true condition raises a new request.
- R8: A write to channel n's control register at offset 0x88 + 0x10*n stores all 32 bits, which then read back unchanged.
- R9: A control write with bit 24 set, while enable-register bit 3+4*n is set, produces a start pulse on channel n in the following cycle only.
- R10: A control write with bit 24 clear, or one made while bit 3+4*n of the enable register is clear, produces no start pulse.
- R11: The enable register at offset 0xF0 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data (combinational) |
| ch_done | input | NUM_CH | Per-channel completion pulses |
| ch_start | output | NUM_CH | Per-channel start pulses |
| irq_req | output | 1 | One-cycle request toward interrupt status bit 3 |

## Verification
The bench builds the block with its defaults, NUM_CH = 7 and ADDR_W = 8. With these values all seven completion flags (bits 24..30) are in use. The last channel, at offset 0xE8 and gated by enable bit 27, is also reachable, so the bench can test both the lowest and the highest channel. The eight-bit offset covers every mapped register, and the bench also reads an offset that maps to nothing.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned REG_W         = 32;
  localparam logic [7:0]  OFS_ENABLE    = 8'hF0;
  localparam logic [7:0]  OFS_IRQREG    = 8'hF4;
  localparam logic [7:0]  OFS_CTL_BASE  = 8'h88;
  localparam int unsigned OFS_CTL_STEP  = 16;

  localparam int unsigned AUX_W         = 6;
  localparam int unsigned BIT_BUSERR    = 15;
  localparam int unsigned IEN_LSB       = 16;
  localparam int unsigned BIT_GLOBAL    = 23;
  localparam int unsigned FLAG_LSB      = 24;
  localparam int unsigned BIT_SENT      = 31;
  localparam int unsigned MAX_CH        = 7;

  localparam int unsigned CTL_GO_BIT    = 24;
  localparam int unsigned ENA_FIRST     = 3;
  localparam int unsigned ENA_STEP      = 4;

  function automatic logic [REG_W-1:0] irq_wmask(input int unsigned nch);
    logic [REG_W-1:0] m;
    m = '0;
    m[AUX_W-1:0]  = '1;
    m[BIT_BUSERR] = 1'b1;
    m[BIT_GLOBAL] = 1'b1;
    for (int unsigned i = 0; i < nch; i++) m[IEN_LSB+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] irq_fmask(input int unsigned nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nch; i++) m[FLAG_LSB+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] ctl_offset(input int unsigned idx);
    return OFS_CTL_BASE + 8'(idx * OFS_CTL_STEP);
  endfunction

endpackage

// File: rtl/dmairq_rstsync.sv
module dmairq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dmairq_irqreg.sv
module dmairq_irqreg
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] done,
  output logic [REG_W-1:0]  irq_reg,
  output logic              irq_pulse
);
  localparam logic [REG_W-1:0] WMASK = irq_wmask(NUM_CH);
  localparam logic [REG_W-1:0] FMASK = irq_fmask(NUM_CH);
  localparam logic [REG_W-1:0] SMASK = REG_W'(1) << BIT_SENT;
  localparam logic [REG_W-1:0] DEFINED = WMASK | FMASK | SMASK;

  logic [REG_W-1:0]  reg_q, reg_d, base_w;
  logic [NUM_CH-1:0] ien_w, flag_w;
  logic              cond_w, pulse_d, pulse_q, upd_en;

  // next-state: write merge, completion flags, condition and sent latch
  always_comb begin
    base_w = reg_q & ~SMASK;
    if (wr_hit) base_w = (wr_data & WMASK) | (reg_q & ~wr_data & FMASK);
    ien_w  = base_w[IEN_LSB +: NUM_CH];
    flag_w = base_w[FLAG_LSB +: NUM_CH] | (done & ien_w);
    reg_d  = base_w & ~FMASK;
    reg_d[FLAG_LSB +: NUM_CH] = flag_w;
    cond_w = (reg_d[BIT_GLOBAL] && (|flag_w)) || reg_d[BIT_BUSERR];
    reg_d[BIT_SENT] = cond_w;
    pulse_d = cond_w && !reg_q[BIT_SENT];
  end

  assign upd_en = wr_hit | (|done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (upd_en) reg_q <= reg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= upd_en & pulse_d;
  end

  assign irq_reg   = reg_q;
  assign irq_pulse = pulse_q;

  AST_PULSE_WITH_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> reg_q[BIT_SENT]);                                           // R6
  AST_NO_REPEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);                                                  // R6
  AST_SENT_IS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[BIT_SENT] == ((reg_q[BIT_GLOBAL] && (|reg_q[FLAG_LSB +: NUM_CH]))
                        || reg_q[BIT_BUSERR]));                             // R5
  AST_FLAG_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_q[FLAG_LSB +: NUM_CH] & ~$past(reg_q[FLAG_LSB +: NUM_CH])
      & ~reg_q[IEN_LSB +: NUM_CH]) == '0));                                 // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q & ~DEFINED) == '0);                                              // R2
endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan
  import dmairq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              chan_ena,
  output logic [REG_W-1:0]  ctl,
  output logic              start
);
  localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(ctl_offset(IDX));

  logic [REG_W-1:0] ctl_q;
  logic             hit_w, start_d, start_q;

  always_comb begin
    hit_w   = wr_en && (wr_addr == MY_OFS);
    start_d = hit_w && wr_data[CTL_GO_BIT] && chan_ena;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (hit_w) ctl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign ctl   = ctl_q;
  assign start = start_q;

  AST_START_HAS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ctl_q[CTL_GO_BIT]);                                         // R9
  AST_START_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(chan_ena));                                           // R10
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !$past(hit_w, 1)) |-> 1'b0);                                // R9
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] ch_done,
  output logic [NUM_CH-1:0] ch_start,
  output logic              irq_req
);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_IRQREG = ADDR_W'(OFS_IRQREG);

  logic                         rst_n_i;
  logic [REG_W-1:0]             ena_q;
  logic [REG_W-1:0]             irq_reg_w;
  logic [NUM_CH-1:0][REG_W-1:0] ctl_w;
  logic                         ena_hit, irq_hit;

  dmairq_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    ena_hit = wr_en && (wr_addr == A_ENABLE);
    irq_hit = wr_en && (wr_addr == A_IRQREG);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     ena_q <= '0;
    else if (ena_hit) ena_q <= wr_data;
  end

  dmairq_irqreg #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_hit    (irq_hit),
    .wr_data   (wr_data),
    .done      (ch_done),
    .irq_reg   (irq_reg_w),
    .irq_pulse (irq_req)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dmairq_chan #(.ADDR_W(ADDR_W), .IDX(g)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .chan_ena (ena_q[ENA_FIRST + ENA_STEP*g]),
      .ctl      (ctl_w[g]),
      .start    (ch_start[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_ENABLE)      rd_data = ena_q;
    else if (rd_addr == A_IRQREG) rd_data = irq_reg_w;
    for (int unsigned i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(ctl_offset(i))) rd_data = ctl_w[i];
    end
  end

  initial begin
    AST_CH_COUNT: assert (NUM_CH >= 1 && NUM_CH <= MAX_CH && ADDR_W >= 8);  // R8
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (ch_start == '0 && !irq_req));                       // R1
endmodule

// File: tb/dmairq_ctrl_test.sv
module dmairq_ctrl_test;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [7:0]     wr_addr;
  logic [31:0]    wr_data;
  logic [7:0]     rd_addr;
  logic [31:0]    rd_data;
  logic [NCH-1:0] ch_done;
  logic [NCH-1:0] ch_start;
  logic           irq_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic           irq;
    logic [NCH-1:0] st;
    string          tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  dmairq_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_done(ch_done), .ch_start(ch_start), .irq_req(irq_req)
  );

  // monitor: compares pulse outputs after each edge against the queue
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (irq_req !== e.irq || ch_start !== e.st) begin
          errors++;
          $display("FAIL %s: irq=%b start=%b expected irq=%b start=%b",
                   e.tag, irq_req, ch_start, e.irq, e.st);
        end
      end
    end
  end

  task automatic tick(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn, input logic eirq,
                      input logic [NCH-1:0] est, input string tag);
    exp_t e;
    wr_en = we; wr_addr = a; wr_data = d; ch_done = dn;
    e.irq = eirq; e.st = est; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic eirq,
                    input logic [NCH-1:0] est, input string tag);
    tick(1'b1, a, d, '0, eirq, est, tag);
  endtask

  task automatic done(input logic [NCH-1:0] dn, input logic eirq, input string tag);
    tick(1'b0, 8'h00, 32'h0, dn, eirq, '0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 32'h0, '0, 1'b0, '0, tag);
  endtask

  task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: read %02h = %08h expected %08h", tag, a, rd_data, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ch_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4, "R1 reset quiet");
    check_rd(8'hF4, 32'h0, "R1 irq reg reset");
    check_rd(8'hF0, 32'h0, "R1 enable reset");
    check_rd(8'h88, 32'h0, "R1 ctl0 reset");
    check_rd(8'hE8, 32'h0, "R1 ctl6 reset");
    check_rd(8'h84, 32'h0, "R1 unmapped reads zero");

    // R2 / R6: writable field mask, bus error raises request
    wr(8'hF4, 32'hFFFF_FFFF, 1'b1, '0, "R2 R6 all-ones write");
    check_rd(8'hF4, 32'h80FF_803F, "R2 writable mask with sent");
    // R7: condition false clears sent, then rearm
    wr(8'hF4, 32'h0, 1'b0, '0, "R7 clear");
    check_rd(8'hF4, 32'h0, "R7 sent cleared");
    wr(8'hF4, 32'h0000_8000, 1'b1, '0, "R7 rearmed request");
    wr(8'hF4, 32'h0000_8000, 1'b0, '0, "R6 no second request");
    check_rd(8'hF4, 32'h8000_8000, "R6 sent held");
    wr(8'hF4, 32'h0, 1'b0, '0, "R7 clear again");

    // R4 / R3: completion flags
    wr(8'hF4, 32'h0081_0000, 1'b0, '0, "R5 enables no flag");
    check_rd(8'hF4, 32'h0081_0000, "R2 enables stored");
    done(7'h03, 1'b1, "R4 done ch0 ch1");
    check_rd(8'hF4, 32'h8181_0000, "R4 only enabled flag set");
    done(7'h01, 1'b0, "R6 done while sent");
    wr(8'hF4, 32'h0081_0000, 1'b0, '0, "R3 zero keeps flag");
    check_rd(8'hF4, 32'h8181_0000, "R3 flag kept");
    wr(8'hF4, 32'h7E81_0000, 1'b0, '0, "R3 ones on clear flags");
    check_rd(8'hF4, 32'h8181_0000, "R3 no flag set by write");
    wr(8'hF4, 32'h0181_0000, 1'b0, '0, "R3 ack flag");
    check_rd(8'hF4, 32'h0081_0000, "R3 R7 flag cleared sent cleared");

    // R5: global enable gates flags
    wr(8'hF4, 32'h0001_0000, 1'b0, '0, "R5 global off");
    done(7'h01, 1'b0, "R5 flag without global");
    check_rd(8'hF4, 32'h0101_0000, "R5 flag stored no sent");
    wr(8'hF4, 32'h0081_0000, 1'b1, '0, "R5 global on raises request");
    check_rd(8'hF4, 32'h8181_0000, "R5 sent set");
    wr(8'hF4, 32'h7F00_0000, 1'b0, '0, "R3 clear all");
    check_rd(8'hF4, 32'h0, "R3 all cleared");
    done(7'h40, 1'b0, "R4 done ch6 not enabled");
    check_rd(8'hF4, 32'h0, "R4 ignored done");

    // R8..R11: channel trigger
    wr(8'hF0, 32'h0000_0008, 1'b0, '0, "R11 enable ch0");
    check_rd(8'hF0, 32'h0000_0008, "R11 enable readback");
    wr(8'h88, 32'h0100_0000, 1'b0, 7'h01, "R9 start ch0");
    idle(1, "R9 single pulse");
    check_rd(8'h88, 32'h0100_0000, "R8 ctl0 stored");
    wr(8'h98, 32'h0100_0000, 1'b0, '0, "R10 ch1 disabled");
    check_rd(8'h98, 32'h0100_0000, "R8 ctl1 stored");
    wr(8'h88, 32'h0000_0001, 1'b0, '0, "R10 go bit clear");
    wr(8'hF0, 32'h0800_0000, 1'b0, '0, "R11 enable ch6");
    wr(8'hE8, 32'h0100_0002, 1'b0, 7'h40, "R9 start ch6");
    check_rd(8'hE8, 32'h0100_0002, "R8 ctl6 stored");
    wr(8'h88, 32'h0100_0000, 1'b0, '0, "R10 ch0 now disabled");
    wr(8'hF0, 32'hDEAD_BEEF, 1'b0, '0, "R11 full word");
    check_rd(8'hF0, 32'hDEAD_BEEF, "R11 full readback");
    idle(3, "R1 idle tail");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule